// File: doc/BRIEF.md
# Packed Decimal to Extended-Float Stack Loader

This block takes an 80-bit signed packed-decimal operand, turns it into an exact 80-bit extended-precision binary floating-point value and pushes that value onto an eight-entry register stack. A one-cycle start pulse hands over the operand. The block then runs for a fixed number of cycles: one digit-accumulation step per decimal digit, one normalisation cycle and one push cycle. At the end it pulses a done strobe.

The push moves a 3-bit top-of-stack pointer down by one, modulo the depth, and writes the new top register. If that register still holds a value, the push is a stack overflow. In that case the block stores the default quiet NaN in place of the converted value, raises the overflow condition flag and pulses a stack-fault indication. Digits are not validated. A nibble above 9 gives an unspecified result.

A synchronous read port lets the surrounding datapath fetch any stack register.

Top module: `bcd_ext_loader`

## Requirements
- R1: After reset: `top_o` is 0, `empty_o` is all ones, and `busy_o`, `done_o`, `c1_o` and `stack_fault_o` are all 0.
- R2: The operand carries 18 decimal digits in bits 71:0, with the least significant digit in bits 3:0, and the sign in bit 79. A nonzero magnitude gives an exact result: sign in bit 79, exponent biased by 16383 in bits 78:64, and a normalised 64-bit significand in bits 63:0 whose bit 63 is 1.
- R3: A zero magnitude gives exponent 0 and significand 0. The sign bit is kept, so a negative zero operand produces 8000_0000_0000_0000_0000h.
- R4: Operand bits 78:72 have no effect on the result.
- R5: Each push sets `top_o` to the old value minus 1, modulo 8. It writes the result into the register at the new top and clears that register's `empty_o` bit (1 = empty).
- R6: When the target register is non-empty, the push writes FFFF_C000_0000_0000_0000h instead of the result. It sets `c1_o` to 1, pulses `stack_fault_o` together with `done_o`, and still moves the pointer.
- R7: A push into an empty register leaves `c1_o` at 0 and `stack_fault_o` at 0.
- R8: `done_o` is a one-cycle pulse that rises 20 clock edges after the edge that sampled `start_i`. `busy_o` is 1 from the edge after the start until `done_o` rises, and `busy_o` is 0 while `done_o` is 1.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. It starts no second conversion and changes neither the stored result nor the pointer.
- R10: `rd_data_o` presents the stack register selected by `rd_idx_i` one clock edge after it is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; operand is sampled with it |
| operand_i | input | 80 | Signed packed-decimal operand |
| rd_idx_i | input | 3 | Stack register to read |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| top_o | output | 3 | Top-of-stack pointer |
| empty_o | output | 8 | Per-register empty tags, 1 = empty |
| c1_o | output | 1 | Overflow condition flag of the last push |
| stack_fault_o | output | 1 | Stack-fault pulse, with `done_o` |
| rd_data_o | output | 80 | Registered read data |

## Verification
After a start edge, the pointer, tags, flag and fault pulse all change on edge 20, and `done_o` rises at that same edge. The read data follows one edge after the index changes. The bench drives inputs on falling edges and counts falling edges from the start until `done_o` is seen, then compares that count with 20. It samples every status output at that same falling edge, and checks one falling edge later that the done and fault pulses have dropped. Stack contents are read back through the read port by setting the index on one falling edge and sampling on the next.

// File: rtl/bcdl_pkg.sv
package bcdl_pkg;
  localparam int EXT_W  = 80;
  localparam int SIG_W  = 64;
  localparam int EXP_W  = 15;
  localparam int BIAS   = 16383;
  localparam logic [EXT_W-1:0] DEF_QNAN = {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ACC  = 2'd1,
    S_NORM = 2'd2,
    S_PUSH = 2'd3
  } ld_state_t;
endpackage

// File: rtl/bcdl_accum.sv
module bcdl_accum #(
  parameter int NUM_DIGITS = 18,
  parameter int ACC_W      = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    step,
  input  logic [4*NUM_DIGITS-1:0] digits,
  output logic [ACC_W-1:0]        acc
);
  localparam int BCD_W = 4 * NUM_DIGITS;

  logic [BCD_W-1:0] shreg;
  logic [3:0]       head;

  assign head = shreg[BCD_W-1 -: 4];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      acc   <= '0;
    end else if (load) begin
      shreg <= digits;
      acc   <= '0;
    end else if (step) begin
      acc   <= (acc << 3) + (acc << 1) + ACC_W'(head);
      shreg <= shreg << 4;
    end
  end
endmodule

// File: rtl/bcdl_norm.sv
module bcdl_norm
  import bcdl_pkg::*;
(
  input  logic [SIG_W-1:0] mag,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o
);
  localparam int LZ_W = $clog2(SIG_W) + 1;

  logic [LZ_W-1:0] lz;
  logic            is_zero;

  always_comb begin
    lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (mag[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
  end

  assign is_zero = (mag == '0);

  always_comb begin
    if (is_zero) begin
      exp_o = '0;
      sig_o = '0;
    end else begin
      exp_o = EXP_W'(BIAS + SIG_W - 1) - EXP_W'(lz);
      sig_o = mag << lz;
    end
  end
endmodule

// File: rtl/bcdl_regstack.sv
module bcdl_regstack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata,
  output logic [DEPTH-1:0] empty
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
      always_ff @(posedge clk) begin
        if (rst) empty[g] <= 1'b1;
        else if (we && waddr == PTR_W'(g)) empty[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/bcd_ext_loader.sv
module bcd_ext_loader
  import bcdl_pkg::*;
#(
  parameter int NUM_DIGITS  = 18,
  parameter int STACK_DEPTH = 8,
  localparam int PTR_W = $clog2(STACK_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [EXT_W-1:0]       operand_i,
  input  logic [PTR_W-1:0]       rd_idx_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [PTR_W-1:0]       top_o,
  output logic [STACK_DEPTH-1:0] empty_o,
  output logic                   c1_o,
  output logic                   stack_fault_o,
  output logic [EXT_W-1:0]       rd_data_o
);
  localparam int BCD_W = 4 * NUM_DIGITS;
  localparam int CNT_W = $clog2(NUM_DIGITS);

  ld_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             sign_q;
  logic [EXT_W-1:0] res_q;
  logic [SIG_W-1:0] mag;
  logic [EXP_W-1:0] exp_n;
  logic [SIG_W-1:0] sig_n;
  logic [PTR_W-1:0] new_top;
  logic             ovf;
  logic             launch;
  logic             unused_pad;

  // pad bits between the digit field and the sign have no effect (R4)
  assign unused_pad = ^operand_i[EXT_W-2:BCD_W];

  assign launch  = (state == S_IDLE) && start_i;
  assign new_top = top_o - PTR_W'(1);
  assign ovf     = !empty_o[new_top];
  assign busy_o  = (state != S_IDLE);

  bcdl_accum #(.NUM_DIGITS(NUM_DIGITS), .ACC_W(SIG_W)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .load   (launch),
    .step   (state == S_ACC),
    .digits (operand_i[BCD_W-1:0]),
    .acc    (mag)
  );

  bcdl_norm u_norm (
    .mag   (mag),
    .exp_o (exp_n),
    .sig_o (sig_n)
  );

  bcdl_regstack #(.DEPTH(STACK_DEPTH), .WIDTH(EXT_W)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .we    (state == S_PUSH),
    .waddr (new_top),
    .wdata (ovf ? DEF_QNAN : res_q),
    .raddr (rd_idx_i),
    .rdata (rd_data_o),
    .empty (empty_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      cnt           <= '0;
      sign_q        <= 1'b0;
      res_q         <= '0;
      top_o         <= '0;
      done_o        <= 1'b0;
      c1_o          <= 1'b0;
      stack_fault_o <= 1'b0;
    end else begin
      done_o        <= 1'b0;
      stack_fault_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            sign_q <= operand_i[EXT_W-1];
            cnt    <= '0;
            state  <= S_ACC;
          end
        end
        S_ACC: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(NUM_DIGITS - 1)) state <= S_NORM;
        end
        S_NORM: begin
          res_q <= {sign_q, exp_n, sig_n};
          state <= S_PUSH;
        end
        S_PUSH: begin
          top_o         <= new_top;
          c1_o          <= ovf;
          stack_fault_o <= ovf;
          done_o        <= 1'b1;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcdl_checker.sv
module bcdl_checker #(
  parameter int STACK_DEPTH = 8,
  localparam int PTR_W = $clog2(STACK_DEPTH)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [PTR_W-1:0]       top_o,
  input logic [STACK_DEPTH-1:0] empty_o,
  input logic                   c1_o,
  input logic                   stack_fault_o
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_fault_flag_R6: assert property (@(posedge clk) disable iff (rst)
    stack_fault_o |-> (c1_o && done_o));

  assert_top_step_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> top_o == PTR_W'($past(top_o) - PTR_W'(1)));

  assert_top_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(top_o));

  assert_tag_set_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !empty_o[top_o]);

  assert_tags_fill_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(empty_o) <= $countones($past(empty_o)));
endmodule

bind bcd_ext_loader bcdl_checker #(.STACK_DEPTH(STACK_DEPTH)) u_bcdl_checker (
  .clk           (clk),
  .rst           (rst),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .top_o         (top_o),
  .empty_o       (empty_o),
  .c1_o          (c1_o),
  .stack_fault_o (stack_fault_o)
);

// File: tb/tb_bcd_ext_loader.sv
module tb_bcd_ext_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [79:0] operand_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic        busy_o, done_o, c1_o, stack_fault_o;
  logic [2:0]  top_o;
  logic [7:0]  empty_o;
  logic [79:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  localparam logic [79:0] QNAN = 80'hFFFF_C000_0000_0000_0000;

  // {operand, expected result}
  localparam logic [159:0] VEC [8] = '{
    {80'h0000_0000_0000_0000_0000, 80'h0000_0000_0000_0000_0000},
    {80'h0000_0000_0000_0000_0001, 80'h3FFF_8000_0000_0000_0000},
    {80'h8000_0000_0000_0000_0001, 80'hBFFF_8000_0000_0000_0000},
    {80'h0000_0000_0000_0000_0010, 80'h4002_A000_0000_0000_0000},
    {80'h8000_0000_0000_0000_0000, 80'h8000_0000_0000_0000_0000},
    {80'h0000_0000_0000_0000_0099, 80'h4005_C600_0000_0000_0000},
    {80'h0099_9999_9999_9999_9999, 80'h403A_DE0B_6B3A_763F_FFF0},
    {80'h7F00_0000_0000_0000_1234, 80'h4009_9A40_0000_0000_0000}
  };

  bcd_ext_loader dut (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .operand_i     (operand_i),
    .rd_idx_i      (rd_idx_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .top_o         (top_o),
    .empty_o       (empty_o),
    .c1_o          (c1_o),
    .stack_fault_o (stack_fault_o),
    .rd_data_o     (rd_data_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  // returns the number of falling edges from start until done is seen
  task automatic push(input logic [79:0] op, output int n, output logic busy_seen);
    @(negedge clk);
    start_i   = 1'b1;
    operand_i = op;
    @(negedge clk);
    start_i   = 1'b0;
    busy_seen = busy_o;
    n = 0;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n = n + 1;
    end
  endtask

  task automatic read_reg(input logic [2:0] idx, output logic [79:0] val);
    @(negedge clk) rd_idx_i = idx;
    @(negedge clk) val = rd_data_o;
  endtask

  initial begin
    int n;
    logic bs;
    logic [79:0] rv;

    do_reset();
    chk("R1 top", 80'(top_o), 80'd0);
    chk("R1 empty", 80'(empty_o), 80'hFF);
    chk("R1 busy/done", 80'({busy_o, done_o}), 80'd0);
    chk("R1 c1/fault", 80'({c1_o, stack_fault_o}), 80'd0);

    for (int i = 0; i < 8; i++) begin
      push(VEC[i][159:80], n, bs);
      chk("R8 latency", 80'(n), 80'd20);
      chk("R8 busy", 80'(bs), 80'd1);
      chk("R8 busy low at done", 80'(busy_o), 80'd0);
      chk("R7 c1/fault", 80'({c1_o, stack_fault_o}), 80'd0);
      chk("R5 top", 80'(top_o), 80'(7 - i));
      chk("R5 tag", 80'(empty_o[7 - i]), 80'd0);
      @(negedge clk);
      chk("R8 pulse", 80'(done_o), 80'd0);
      read_reg(3'(7 - i), rv);
      if (i == 0 || i == 4)      chk("R3 R10 zero", rv, VEC[i][79:0]);
      else if (i == 7)           chk("R4 R10 pad", rv, VEC[i][79:0]);
      else                       chk("R2 R10 value", rv, VEC[i][79:0]);
    end

    // ninth push wraps onto a full register
    push(80'h0000_0000_0000_0000_0005, n, bs);
    chk("R6 c1", 80'(c1_o), 80'd1);
    chk("R6 fault", 80'(stack_fault_o), 80'd1);
    chk("R6 top", 80'(top_o), 80'd7);
    @(negedge clk);
    chk("R6 fault pulse", 80'(stack_fault_o), 80'd0);
    read_reg(3'd7, rv);
    chk("R6 qnan", rv, QNAN);

    // start while busy is ignored
    do_reset();
    chk("R1 empty after refill", 80'(empty_o), 80'hFF);
    @(negedge clk);
    start_i   = 1'b1;
    operand_i = 80'h0000_0000_0000_0000_0001;
    @(negedge clk) start_i = 1'b0;
    repeat (5) @(negedge clk);
    start_i   = 1'b1;
    operand_i = 80'h0000_0000_0000_0000_0099;
    @(negedge clk) start_i = 1'b0;
    operand_i = '0;
    n = 0;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n = n + 1;
    end
    chk("R9 top", 80'(top_o), 80'd7);
    n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (done_o) n = n + 1;
    end
    chk("R9 no second done", 80'(n), 80'd0);
    chk("R9 top held", 80'(top_o), 80'd7);
    chk("R9 tags", 80'(empty_o), 80'h7F);
    read_reg(3'd7, rv);
    chk("R9 R10 first result kept", rv, 80'h3FFF_8000_0000_0000_0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule